// File: doc/BRIEF.md
# Bitfield Memory Access Unit

This unit carries out bitfield instructions whose operand lives in big-endian byte memory, on behalf of a 32-bit core. The core hands over a base byte address, a signed bit offset measured from the most significant bit of that byte, a 5-bit length code, an insert value and an operation code. The unit works out which bytes the field touches. It turns that span into one memory access of 1, 2, 4 or 8 bytes, and places the field inside a 64-bit big-endian window. It then reads the memory once. The modifying operations also write the result back once, to the same address and with the same size.

The operations are: zero-extending extract, sign-extending extract, insert, set, clear, change and find-first-one. The unit returns a result word and a flag source word. The flag source word holds the field left-justified in 32 bits, so that its bit 31 gives the negative flag and a zero word gives the zero flag.

Memory is reached through a single request/acknowledge port. The address and the size code are held until the acknowledge. Read data arrives right-justified in 64 bits, and write data leaves the same way.

Top module: `bfield_mem_unit`

## Requirements
- R1: After reset, busy_o, done_o and mem_req_o are all 0.
- R2: A length code of 0 selects a 32-bit field; a code n of 1 to 31 selects n bits.
- R3: The field starts at absolute bit position 8*base + offset, where offset is a signed two's-complement value and bit 0 of each byte is its MSB. A negative offset reaches bytes below the base address.
- R4: With byte address floor(pos/8), bit remainder pos mod 8 and span = (remainder + length − 1)/8, the access size is as follows. A span of 0 gives code 0 (1 byte). A span of 1 gives code 1 (2 bytes). A span of 2 or 3 gives code 2 (4 bytes); for a span of 2 at an odd byte address, the access starts one byte lower.
- R5: A span of 4 gives code 3 (8 bytes), with the access address equal to the byte address with its two low bits cleared.
- R6: Opcode 0 returns the field zero-extended and opcode 1 returns it sign-extended. For every opcode except 2, nval_o is the field left-justified in 32 bits with zeros below it.
- R7: Opcode 2 writes the low length bits of ins_val_i into the field and leaves every other memory bit unchanged. result_o and nval_o both return those bits left-justified.
- R8: Opcodes 3, 4 and 5 set, clear or invert every field bit and leave the other bits unchanged. result_o returns the old field left-justified.
- R9: Opcode 6 returns offset + i, where i is the index from the field's MSB of its first 1 bit. When the field is all zeros, it returns offset + length. Memory is not written.
- R10: Every operation makes exactly one read. Opcodes 2 to 5 then make exactly one write, with the read's address and size. Request signals hold until acknowledged, and done_o pulses for one cycle after the last acknowledge.
- R11: A start_i that arrives while busy_o is 1 is ignored. The operation in flight completes with its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; taken only when idle |
| op_i | input | 3 | Operation code (0 extu, 1 exts, 2 insert, 3 set, 4 clear, 5 change, 6 find-first-one) |
| base_addr_i | input | AW | Base byte address |
| bit_ofs_i | input | 32 | Signed bit offset |
| len_i | input | 5 | Field length code, 0 means 32 |
| ins_val_i | input | 32 | Insert value, right-justified |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Operation result |
| nval_o | output | 32 | Field left-justified, source of the N and Z flags |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | AW | Access byte address |
| mem_size_o | output | 2 | Size code: 0 byte, 1 two bytes, 2 four bytes, 3 eight bytes |
| mem_wdata_o | output | 64 | Write data, right-justified big-endian |
| mem_ack_i | input | 1 | Memory acknowledge, ends the request |
| mem_rdata_i | input | 64 | Read data, right-justified big-endian, valid with the acknowledge |

## Verification
Two things can land in the same cycle. One is a fresh start_i from the core. The other is the unit's own in-flight memory phase, which is either a stalled read waiting for its acknowledge or the write of a read-modify-write. The bench provokes this by stretching the memory acknowledge over several cycles and pulsing start_i mid-read, with operands that differ in operation and address. It then judges the overlap by three things: the result and the final memory image must match the first operation alone, exactly one read and one write must appear, and the unit must go idle with no further traffic.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int OFS_W  = 32;
  localparam int LEN_W  = 5;
  localparam int WORD_W = 32;
  localparam int LINE_W = 64;
  localparam int BOFS_W = $clog2(LINE_W);
  localparam int FLEN_W = LEN_W + 1;

  typedef enum logic [2:0] {
    OP_EXTU = 3'd0,
    OP_EXTS = 3'd1,
    OP_INS  = 3'd2,
    OP_SET  = 3'd3,
    OP_CLR  = 3'd4,
    OP_CHG  = 3'd5,
    OP_FFO  = 3'd6
  } bf_op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } bf_size_e;

  function automatic logic [LINE_W-1:0] size_mask(bf_size_e s);
    logic [LINE_W-1:0] m;
    case (s)
      SZ_B:    m = LINE_W'(64'h0000_0000_0000_00ff);
      SZ_H:    m = LINE_W'(64'h0000_0000_0000_ffff);
      SZ_W:    m = LINE_W'(64'h0000_0000_ffff_ffff);
      default: m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/bf_addr_calc.sv
module bf_addr_calc
  import bf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]     base_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [LEN_W-1:0]  len_code_i,
  output logic [AW-1:0]     addr_o,
  output logic [BOFS_W-1:0] bofs_o,
  output logic [FLEN_W-1:0] len_o,
  output bf_size_e          size_o
);
  logic signed [OFS_W-1:0] byte_step;
  logic [AW-1:0]           a0;
  logic [2:0]              b0;
  logic [6:0]              last_bit;
  logic [2:0]              span;

  always_comb begin
    len_o     = (len_code_i == '0) ? FLEN_W'(WORD_W) : {1'b0, len_code_i};
    byte_step = $signed(ofs_i) >>> 3;
    a0        = base_i + AW'(byte_step);
    b0        = ofs_i[2:0];
    last_bit  = 7'(b0) + 7'(len_o) - 7'd1;
    span      = last_bit[5:3];
    addr_o    = a0;
    bofs_o    = BOFS_W'(b0);
    size_o    = SZ_B;
    case (span)
      3'd0: bofs_o = BOFS_W'(b0) + BOFS_W'(56);
      3'd1: begin
        size_o = SZ_H;
        bofs_o = BOFS_W'(b0) + BOFS_W'(48);
      end
      3'd2: begin
        size_o = SZ_W;
        if (a0[0]) begin
          addr_o = a0 - AW'(1);
          bofs_o = BOFS_W'(b0) + BOFS_W'(40);
        end else begin
          bofs_o = BOFS_W'(b0) + BOFS_W'(32);
        end
      end
      3'd3: begin
        size_o = SZ_W;
        bofs_o = BOFS_W'(b0) + BOFS_W'(32);
      end
      default: begin
        size_o = SZ_D;
        bofs_o = BOFS_W'(b0) + {1'b0, a0[1:0], 3'b000};
        addr_o = a0 & ~AW'(3);
      end
    endcase
  end

  // R4
  always_comb begin
    span_fit_chk: assert (7'(bofs_o) + 7'(len_o) <= 7'(LINE_W))
      else $error("field overruns 64-bit window");
  end
endmodule

// File: rtl/bf_clz.sv
module bf_clz #(
  parameter int W  = 32,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/bf_field_ops.sv
module bf_field_ops
  import bf_pkg::*;
(
  input  logic [LINE_W-1:0] data_i,
  input  logic [BOFS_W-1:0] bofs_i,
  input  logic [FLEN_W-1:0] len_i,
  input  bf_op_e            op_i,
  input  logic [WORD_W-1:0] ins_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [LINE_W-1:0] wdata_o,
  output logic [WORD_W-1:0] result_o,
  output logic [WORD_W-1:0] nval_o,
  output logic              writes_o
);
  localparam int CW = $clog2(WORD_W) + 1;

  logic [6:0]        sh_lo;
  logic [5:0]        rsh;
  logic [LINE_W-1:0] mask;
  logic [LINE_W-1:0] lj;
  logic [WORD_W-1:0] fld;
  logic [WORD_W-1:0] ins_lj;
  logic [LINE_W-1:0] ins_line;
  logic [CW-1:0]     lz;
  logic [OFS_W-1:0]  ffo;

  bf_clz #(.W(WORD_W)) u_clz (.vec_i(fld), .cnt_o(lz));

  always_comb begin
    sh_lo    = 7'(LINE_W) - 7'(len_i);
    rsh      = 6'(WORD_W) - 6'(len_i);
    mask     = ({LINE_W{1'b1}} << sh_lo) >> bofs_i;
    lj       = (data_i & mask) << bofs_i;
    fld      = lj[LINE_W-1 -: WORD_W];
    ins_lj   = ins_i << rsh;
    ins_line = {ins_lj, {(LINE_W-WORD_W){1'b0}}} >> bofs_i;
    ffo      = ofs_i + ((fld != '0) ? OFS_W'(lz) : OFS_W'(len_i));
    wdata_o  = data_i;
    nval_o   = fld;
    writes_o = 1'b0;
    case (op_i)
      OP_EXTS: result_o = $unsigned($signed(fld) >>> rsh);
      OP_INS: begin
        wdata_o  = (data_i & ~mask) | ins_line;
        result_o = ins_lj;
        nval_o   = ins_lj;
        writes_o = 1'b1;
      end
      OP_SET: begin
        wdata_o  = data_i | mask;
        result_o = fld;
        writes_o = 1'b1;
      end
      OP_CLR: begin
        wdata_o  = data_i & ~mask;
        result_o = fld;
        writes_o = 1'b1;
      end
      OP_CHG: begin
        wdata_o  = data_i ^ mask;
        result_o = fld;
        writes_o = 1'b1;
      end
      OP_FFO:  result_o = ffo;
      default: result_o = fld >> rsh;
    endcase
  end
endmodule

// File: rtl/bfield_mem_unit.sv
module bfield_mem_unit
  import bf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [AW-1:0]     base_addr_i,
  input  logic [OFS_W-1:0]  bit_ofs_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [WORD_W-1:0] ins_val_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] result_o,
  output logic [WORD_W-1:0] nval_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [LINE_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [LINE_W-1:0] mem_rdata_i
);
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_DONE} st_e;

  st_e               state_q;
  bf_op_e            op_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [WORD_W-1:0] ins_q;
  logic [AW-1:0]     addr_q;
  logic [BOFS_W-1:0] bofs_q;
  logic [FLEN_W-1:0] len_q;
  bf_size_e          size_q;
  logic [WORD_W-1:0] res_q, nval_q;
  logic [LINE_W-1:0] wdata_q;

  logic [AW-1:0]     c_addr;
  logic [BOFS_W-1:0] c_bofs;
  logic [FLEN_W-1:0] c_len;
  bf_size_e          c_size;
  logic [LINE_W-1:0] f_wdata;
  logic [WORD_W-1:0] f_res, f_nval;
  logic              f_writes;

  bf_addr_calc #(.AW(AW)) u_addr (
    .base_i    (base_addr_i),
    .ofs_i     (bit_ofs_i),
    .len_code_i(len_i),
    .addr_o    (c_addr),
    .bofs_o    (c_bofs),
    .len_o     (c_len),
    .size_o    (c_size)
  );

  bf_field_ops u_ops (
    .data_i  (mem_rdata_i & size_mask(size_q)),
    .bofs_i  (bofs_q),
    .len_i   (len_q),
    .op_i    (op_q),
    .ins_i   (ins_q),
    .ofs_i   (ofs_q),
    .wdata_o (f_wdata),
    .result_o(f_res),
    .nval_o  (f_nval),
    .writes_o(f_writes)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_EXTU;
      ofs_q   <= '0;
      ins_q   <= '0;
      addr_q  <= '0;
      bofs_q  <= '0;
      len_q   <= '0;
      size_q  <= SZ_B;
      res_q   <= '0;
      nval_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          op_q    <= bf_op_e'(op_i);
          ofs_q   <= bit_ofs_i;
          ins_q   <= ins_val_i;
          addr_q  <= c_addr;
          bofs_q  <= c_bofs;
          len_q   <= c_len;
          size_q  <= c_size;
          state_q <= ST_RD;
        end
        ST_RD: if (mem_ack_i) begin
          res_q   <= f_res;
          nval_q  <= f_nval;
          wdata_q <= f_wdata & size_mask(size_q);
          state_q <= f_writes ? ST_WR : ST_DONE;
        end
        ST_WR: if (mem_ack_i) state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign mem_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_addr_o  = addr_q;
  assign mem_size_o  = size_q;
  assign mem_wdata_o = wdata_q;
  assign result_o    = res_q;
  assign nval_o      = nval_q;

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_size_o) && $stable(mem_we_o));
  // R10
  rd_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> !mem_we_o);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  wr_to_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ack_i |=> done_o && !mem_req_o);
  // R5
  dword_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && (mem_size_o == 2'd3) |-> (mem_addr_o[1:0] == 2'b00));
  // R11
  start_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(mem_addr_o) && $stable(mem_size_o));
endmodule

// File: tb/bfield_mem_unit_tb.sv
module bfield_mem_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] base = '0, ofs = '0, ins = '0;
  logic [4:0]  lcode = '0;
  logic        busy, done, mem_req, mem_we, mem_ack;
  logic [31:0] result, nval, mem_addr;
  logic [1:0]  mem_size;
  logic [63:0] mem_wdata, mem_rdata;

  int n_chk = 0, n_fail = 0;
  int lat = 0;
  logic [3:0] wcnt = '0;
  logic fill_en = 1'b0;
  int fill_seed = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] rd_addr = '0, wr_addr = '0;
  logic [1:0]  rd_size = '0, wr_size = '0;
  logic [7:0] mem [0:127];

  always #10 clk = ~clk;

  bfield_mem_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .base_addr_i(base), .bit_ofs_i(ofs), .len_i(lcode), .ins_val_i(ins),
    .busy_o(busy), .done_o(done), .result_o(result), .nval_o(nval),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_size_o(mem_size), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] pat(int k, int s);
    if (s == 0) return 8'h00;
    if (s == 1) return 8'hff;
    return 8'(k * 37 + s * 11 + 5);
  endfunction

  assign mem_ack = mem_req && (wcnt == 4'(lat));

  always_comb begin
    mem_rdata = '0;
    for (int k = 0; k < 8; k++)
      if (k < (1 << mem_size)) mem_rdata = {mem_rdata[55:0], mem[(int'(mem_addr) + k) & 127]};
  end

  always @(posedge clk) begin
    if (!mem_req || mem_ack) wcnt <= '0; else wcnt <= wcnt + 4'd1;
    if (fill_en) begin
      for (int k = 0; k < 128; k++) mem[k] <= pat(k, fill_seed);
    end else if (mem_req && mem_we && mem_ack) begin
      for (int k = 0; k < 8; k++)
        if (k < (1 << mem_size))
          mem[(int'(mem_addr) + k) & 127] <= mem_wdata[8*((1 << mem_size) - 1 - k) +: 8];
    end
    if (mem_req && mem_ack) begin
      if (mem_we) begin wr_cnt <= wr_cnt + 1; wr_addr <= mem_addr; wr_size <= mem_size; end
      else begin rd_cnt <= rd_cnt + 1; rd_addr <= mem_addr; rd_size <= mem_size; end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill(int s);
    @(negedge clk); fill_seed = s; fill_en = 1'b1;
    @(negedge clk); fill_en = 1'b0;
  endtask

  function automatic logic bitat(logic [7:0] m [0:127], int pos);
    return m[(pos >>> 3) & 127][7 - (pos & 7)];
  endfunction

  // req: tag of the main requirement; modify ops also cover R10
  task automatic run_op(string req, int o, int b, int f, int lc, logic [31:0] iv,
                        int lat_v, bit dup);
    logic [7:0]  old_m [0:127];
    logic [7:0]  exp_m [0:127];
    logic [31:0] fld, exp_res, exp_nv;
    longint      tmp;
    int len, p0, first, span, b0, ea, es, r0, w0, cyc, bad, pos;
    bit modify, nb;
    lat = lat_v;
    for (int k = 0; k < 128; k++) begin old_m[k] = mem[k]; exp_m[k] = mem[k]; end
    len = (lc == 0) ? 32 : lc;
    p0 = b * 8 + f;
    fld = '0; first = -1;
    for (int i = 0; i < len; i++) begin
      fld[31-i] = bitat(old_m, p0 + i);
      if (fld[31-i] && first < 0) first = i;
    end
    modify = (o >= 2 && o <= 5);
    exp_nv = (o == 2) ? (iv << (32 - len)) : fld;
    case (o)
      1: begin
        tmp = longint'(fld >> (32 - len));
        if (fld[31]) tmp = tmp | ~((longint'(1) << len) - 1);
        exp_res = 32'(tmp);
      end
      2: exp_res = iv << (32 - len);
      3, 4, 5: exp_res = fld;
      6: exp_res = 32'(f + ((first >= 0) ? first : len));
      default: exp_res = fld >> (32 - len);
    endcase
    if (modify) begin
      for (int i = 0; i < len; i++) begin
        pos = p0 + i;
        case (o)
          2: nb = iv[len-1-i];
          3: nb = 1'b1;
          4: nb = 1'b0;
          default: nb = ~bitat(old_m, pos);
        endcase
        exp_m[(pos >>> 3) & 127][7 - (pos & 7)] = nb;
      end
    end
    b0 = p0 & 7; ea = p0 >>> 3;
    span = (b0 + len - 1) / 8;
    case (span)
      0: es = 0;
      1: es = 1;
      2: begin es = 2; if (ea & 1) ea = ea - 1; end
      3: es = 2;
      default: begin es = 3; ea = ea & ~3; end
    endcase
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    op = 3'(o); base = 32'(b); ofs = 32'(f); lcode = 5'(lc); ins = iv; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (dup) begin
      // R11: second start while the read is still stalled
      op = 3'd5; base = 32'd20; ofs = 32'd3; lcode = 5'd9; ins = 32'hffff_ffff; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    chk(req, "completion before timeout", longint'(cyc < 2000), 1);
    chk(req, "result_o", result, exp_res);
    chk(req, "nval_o", nval, exp_nv);
    @(negedge clk);
    @(negedge clk);
    chk("R10", "busy_o idle after done", busy, 0);
    chk("R10", "read count", rd_cnt - r0, 1);
    chk("R10", "write count", wr_cnt - w0, modify ? 1 : 0);
    chk("R4", "read address", rd_addr, ea);
    chk("R4", "read size code", rd_size, es);
    if (modify) begin
      chk("R10", "write address", wr_addr, ea);
      chk("R10", "write size code", wr_size, es);
    end
    bad = 0;
    for (int k = 0; k < 128; k++) if (mem[k] !== exp_m[k]) bad++;
    chk(req, "memory bytes differing from model", bad, 0);
  endtask

  bit finished = 1'b0;

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy_o in reset", busy, 0);
    chk("R1", "done_o in reset", done, 0);
    chk("R1", "mem_req_o in reset", mem_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "mem_req_o after reset", mem_req, 0);

    fill(7);
    run_op("R6", 0, 40, 3, 5, 32'h0, 0, 1'b0);         // byte span
    run_op("R6", 1, 40, 10, 7, 32'h0, 1, 1'b0);        // signed, halfword
    run_op("R2", 1, 41, 4, 0, 32'h0, 0, 1'b0);         // 32-bit field, 8-byte access
    run_op("R5", 0, 43, 30, 30, 32'h0, 2, 1'b0);       // unaligned 8-byte access
    run_op("R3", 0, 50, -13, 6, 32'h0, 0, 1'b0);       // negative offset
    run_op("R3", 1, 60, -70, 11, 32'h0, 1, 1'b0);
    run_op("R4", 0, 41, 2, 20, 32'h0, 0, 1'b0);        // span 2 at odd address
    run_op("R4", 0, 40, 4, 8, 32'h0, 0, 1'b0);         // span 1
    run_op("R4", 0, 44, 6, 26, 32'h0, 0, 1'b0);        // span 3
    run_op("R7", 2, 45, 5, 12, 32'h0000_0a5c, 2, 1'b0);
    run_op("R7", 2, 46, 7, 0, 32'hdead_beef, 0, 1'b0); // 32-bit insert, 8-byte access
    run_op("R8", 3, 48, 9, 10, 32'h0, 0, 1'b0);
    run_op("R8", 4, 49, -3, 17, 32'h0, 1, 1'b0);
    run_op("R8", 5, 52, 21, 23, 32'h0, 0, 1'b0);
    run_op("R9", 6, 54, 5, 14, 32'h0, 0, 1'b0);
    fill(1);
    run_op("R9", 6, 54, -6, 3, 32'h0, 0, 1'b0);        // first bit is field MSB
    fill(0);
    run_op("R9", 6, 56, -3, 9, 32'h0, 0, 1'b0);        // zero field: offset + length
    run_op("R9", 6, 56, 12, 0, 32'h0, 1, 1'b0);
    fill(9);
    run_op("R11", 2, 60, 13, 15, 32'h0000_6b31, 4, 1'b1);
    run_op("R11", 0, 62, -5, 7, 32'h0, 5, 1'b1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule